// File: doc/BRIEF.md
# SPI Register Slave for a Managed Switch

This block is the configuration port of a small Ethernet switch. An external controller talks to it over a mode 0 SPI link (clock idles low, data sampled on the rising edge, bytes sent MSB first). Every transaction opens with a two-byte header, most significant byte first, that carries a command and a register address. After the header, any number of data bytes follow. On a write, each byte lands in the addressed register. On a read, each byte is shifted back out. The address steps by one after every data byte.

The SPI inputs are brought into the system clock domain through two-flop synchronisers and then edge-detected. The serial clock must therefore be slower than the system clock. The simulation runs it at one sixteenth of the system clock.

Register 0 is a fixed family code. Register 1 carries a read-only chip code and revision in its upper seven bits and a writable run bit in bit 0. The run bit drives the `run` output. The remaining registers in the space are plain read/write bytes. All registers appear in parallel on `reg_image` for the switch logic.

The parameter `HDR_ALT` selects the header layout:
- `HDR_ALT = 0`: an 8-bit command followed by an 8-bit address.
- `HDR_ALT = 1`: a 3-bit command, then a 12-bit address, then one unused trailing bit.

Top module: `spi_swreg`

## Requirements
- R1: After reset, `run` is 0 and `spi_miso` is 0. Every read/write register holds 0x00. `reg_image` byte 0 is 0x95 and byte 1 is 0x02 (chip code 0, revision 1, run 0).
- R2: A header with command 0x02 followed by data bytes writes each data byte into the addressed register. The new value appears on `reg_image[8*a +: 8]`.
- R3: A header with command 0x03 returns the addressed register on `spi_miso`, MSB first. Each bit changes only after a falling edge of `spi_sclk`, so it is stable at the following rising edge.
- R4: Within one transaction, each further data byte uses the address one above the previous one, for both reads and writes.
- R5: Address 0x00 always reads 0x95, and writes to it have no effect.
- R6: Address 0x01 reads as {chip code[3:0], revision[2:0], run}. Only bit 0 of a written byte is kept, and it sets `run`.
- R7: Addresses at or above the depth (0x80 by default) read 0x00, and writes to them are ignored.
- R8: Raising `spi_cs_n` at any point ends the transaction and drops a partly received byte. The next selection starts again with a fresh header.
- R9: If `spi_cs_n` rises together with the rising clock edge that would complete a data byte, that byte is not written.
- R10: A command other than 0x02 or 0x03 writes nothing, and `spi_miso` stays 0 for the rest of the transaction.
- R11: With `HDR_ALT` = 1, the header bits are, from MSB to LSB, a 3-bit command (2 = write, 3 = read), a 12-bit address and one ignored bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI select, active low |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller, 0 when deselected |
| run | output | 1 | Switch run flag (register 1 bit 0) |
| reg_image | output | 8*DEPTH | All register bytes; byte a at bits 8*a+7 down to 8*a |

## Verification
Two events can land in the same system clock cycle: the rising clock edge that completes a data byte, and deselection. The bench provokes this by raising `spi_sclk` and `spi_cs_n` at the same instant, so both reach the synchronisers together. It then judges the outcome by reading the register image and reading the register back over SPI: the write must be lost. A separate case cuts a byte off after four bits, then checks that a following transaction decodes its header from bit zero.

// File: rtl/spi_swreg.sv
module spi_swreg #(
  parameter int DEPTH = 128,
  parameter bit HDR_ALT = 1'b0,
  parameter logic [7:0] FAMILY = 8'h95,
  parameter logic [3:0] CHIP = 4'h0,
  parameter logic [2:0] REV = 3'h1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sclk,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  output logic               spi_miso,
  output logic               run,
  output logic [8*DEPTH-1:0] reg_image
);
  localparam int ADDR_W = HDR_ALT ? 12 : 8;
  localparam int IW = $clog2(DEPTH);
  localparam logic [ADDR_W:0] DEPTH_A = (ADDR_W+1)'(DEPTH);

  typedef enum logic [1:0] {OP_NONE, OP_WR, OP_RD} op_t;

  logic [2:0] sclk_q;
  logic [1:0] cs_q, mosi_q;
  logic       active, rise, fall;
  logic [6:0] shift_in;
  logic [7:0] byte_in, hdr_hi, tx, rd_data, id1;
  logic [2:0] bit_cnt;
  logic [1:0] phase;
  op_t        op;
  logic [ADDR_W-1:0] addr, ad_f, rd_sel;
  logic       is_wr, is_rd, byte_done, wr_en, wr_run, wr_mem;
  logic [7:0] mem [2:DEPTH-1];

  assign active  = ~cs_q[1];
  assign rise    = sclk_q[1] & ~sclk_q[2];
  assign fall    = ~sclk_q[1] & sclk_q[2];
  assign byte_in = {shift_in, mosi_q[1]};
  assign id1     = {CHIP, REV, run};

  generate
    if (HDR_ALT) begin : g_alt
      assign is_wr = hdr_hi[7:5] == 3'h2;
      assign is_rd = hdr_hi[7:5] == 3'h3;
      assign ad_f  = {hdr_hi[4:0], byte_in[7:1]};
    end else begin : g_std
      assign is_wr = hdr_hi == 8'h02;
      assign is_rd = hdr_hi == 8'h03;
      assign ad_f  = byte_in;
    end
  endgenerate

  assign byte_done = active & rise & (bit_cnt == 3'd7);
  assign wr_en  = byte_done & (phase == 2'd2) & (op == OP_WR);
  assign wr_run = wr_en & (addr == ADDR_W'(1));
  assign wr_mem = wr_en & (addr >= ADDR_W'(2)) & ({1'b0, addr} < DEPTH_A);
  assign rd_sel = (phase == 2'd1) ? ad_f : addr + 1'b1;

  always_comb begin
    if (rd_sel == '0) rd_data = FAMILY;
    else if (rd_sel == ADDR_W'(1)) rd_data = id1;
    else if ({1'b0, rd_sel} < DEPTH_A) rd_data = mem[rd_sel[IW-1:0]];
    else rd_data = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= 2'b11;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], spi_sclk};
      cs_q   <= {cs_q[0], spi_cs_n};
      mosi_q <= {mosi_q[0], spi_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_in <= '0;
      bit_cnt  <= '0;
      phase    <= '0;
      hdr_hi   <= '0;
      op       <= OP_NONE;
      addr     <= '0;
      tx       <= '0;
      spi_miso <= 1'b0;
    end else if (!active) begin
      bit_cnt  <= '0;
      phase    <= '0;
      op       <= OP_NONE;
      spi_miso <= 1'b0;
    end else begin
      if (rise) begin
        shift_in <= byte_in[6:0];
        bit_cnt  <= bit_cnt + 1'b1;
        if (bit_cnt == 3'd7) begin
          case (phase)
            2'd0: begin
              hdr_hi <= byte_in;
              phase  <= 2'd1;
            end
            2'd1: begin
              phase <= 2'd2;
              addr  <= ad_f;
              op    <= is_wr ? OP_WR : (is_rd ? OP_RD : OP_NONE);
              tx    <= rd_data;
            end
            default: begin
              if (op != OP_NONE) addr <= addr + 1'b1;
              tx <= rd_data;
            end
          endcase
        end
      end
      if (fall)
        spi_miso <= (op == OP_RD && phase == 2'd2) ? tx[~bit_cnt] : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else if (wr_run) run <= byte_in[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 2; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_mem) begin
      mem[addr[IW-1:0]] <= byte_in;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_img
      if (g == 0) begin : g_fam
        assign reg_image[7:0] = FAMILY;
      end else if (g == 1) begin : g_id
        assign reg_image[15:8] = id1;
      end else begin : g_rw
        assign reg_image[8*g +: 8] = mem[g];
      end
    end
  endgenerate
endmodule

// File: rtl/spi_swreg_chk.sv
module spi_swreg_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              fall_evt,
  input logic              miso,
  input logic              wr_en,
  input logic              wr_run,
  input logic              run,
  input logic [ADDR_W-1:0] addr
);
  AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !fall_evt) |=> $stable(miso)); // R3

  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (miso == 1'b0)); // R8

  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (addr == $past(addr) + 1'b1)); // R4

  AST_RUN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(run) |-> $past(wr_run)); // R6
endmodule

bind spi_swreg spi_swreg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(active), .fall_evt(fall),
  .miso(spi_miso), .wr_en(wr_en), .wr_run(wr_run), .run(run), .addr(addr)
);

// File: tb/spi_swreg_bench.sv
module spi_swreg_bench;
  localparam int DEPTH = 128;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, cs2_n = 1'b1, mosi = 1'b0;
  logic miso, miso2, run, run2;
  logic [8*DEPTH-1:0] img, img2;
  logic use_alt = 1'b0;
  int total = 0, bad = 0;
  logic [7:0] rx;

  always #5 clk = ~clk;

  spi_swreg u_spi_swreg (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .run(run), .reg_image(img));

  spi_swreg #(.HDR_ALT(1'b1)) u_spi_swreg_alt (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs2_n),
    .spi_mosi(mosi), .spi_miso(miso2), .run(run2), .reg_image(img2));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel;
    if (use_alt) cs2_n = 1'b0; else cs_n = 1'b0;
    wait_clk(8);
  endtask

  task automatic desel;
    wait_clk(8);
    cs_n = 1'b1;
    cs2_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic xbit(input logic b, output logic r);
    mosi = b;
    wait_clk(8);
    r = use_alt ? miso2 : miso;
    sclk = 1'b1;
    wait_clk(8);
    sclk = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) xbit(t[i], r[i]);
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d);
    sel(); xbyte(8'h02, rx); xbyte(a, rx); xbyte(d, rx); desel();
  endtask

  task automatic rd1(input logic [7:0] a, output logic [7:0] d);
    sel(); xbyte(8'h03, rx); xbyte(a, rx); xbyte(8'h00, d); desel();
  endtask

  task automatic t_reset;
    logic nz = 1'b0;
    check(run == 1'b0, "R1 run", run, 0);
    check(miso == 1'b0, "R1 miso", miso, 0);
    check(img[7:0] == 8'h95, "R1 byte0", img[7:0], 8'h95);
    check(img[15:8] == 8'h02, "R1 byte1", img[15:8], 8'h02);
    for (int a = 2; a < DEPTH; a++) if (img[8*a +: 8] != 8'h00) nz = 1'b1;
    check(!nz, "R1 rw zero", nz, 0);
  endtask

  task automatic t_write;
    wr1(8'h05, 8'hA5);
    check(img[8*5 +: 8] == 8'hA5, "R2 write 0x05", img[8*5 +: 8], 8'hA5);
  endtask

  task automatic t_read;
    logic [7:0] d;
    rd1(8'h05, d);
    check(d == 8'hA5, "R3 read 0x05", d, 8'hA5);
  endtask

  task automatic t_burst;
    logic [7:0] d;
    sel(); xbyte(8'h02, rx); xbyte(8'h10, rx);
    xbyte(8'h11, rx); xbyte(8'h22, rx); xbyte(8'h33, rx); xbyte(8'h44, rx);
    desel();
    check(img[8*16 +: 32] == 32'h44332211, "R4 burst write", img[8*16 +: 32], 32'h44332211);
    sel(); xbyte(8'h03, rx); xbyte(8'h11, rx);
    for (int k = 0; k < 3; k++) begin
      xbyte(8'h00, d);
      check(d == 8'(8'h22 + 8'h11 * k), "R4 burst read", d, 8'h22 + 8'h11 * k);
    end
    desel();
  endtask

  task automatic t_family;
    logic [7:0] d;
    wr1(8'h00, 8'h12);
    rd1(8'h00, d);
    check(d == 8'h95, "R5 family read", d, 8'h95);
    check(img[7:0] == 8'h95, "R5 family image", img[7:0], 8'h95);
  endtask

  task automatic t_run;
    logic [7:0] d;
    wr1(8'h01, 8'h01);
    check(run == 1'b1, "R6 run set", run, 1);
    rd1(8'h01, d);
    check(d == 8'h03, "R6 id1 running", d, 8'h03);
    wr1(8'h01, 8'hFE);
    check(run == 1'b0, "R6 run clear", run, 0);
    rd1(8'h01, d);
    check(d == 8'h02, "R6 id1 stopped", d, 8'h02);
  endtask

  task automatic t_range;
    logic [7:0] d;
    sel(); xbyte(8'h02, rx); xbyte(8'h7F, rx); xbyte(8'h5A, rx); xbyte(8'hC3, rx); desel();
    check(img[8*127 +: 8] == 8'h5A, "R7 last in range", img[8*127 +: 8], 8'h5A);
    rd1(8'h80, d);
    check(d == 8'h00, "R7 read beyond", d, 0);
    check(img[15:0] == 16'h0295, "R7 no wrap", img[15:0], 16'h0295);
  endtask

  task automatic t_abort;
    logic r;
    sel(); xbyte(8'h02, rx); xbyte(8'h20, rx);
    for (int i = 0; i < 4; i++) xbit(1'b1, r);
    desel();
    check(img[8*32 +: 8] == 8'h00, "R8 partial dropped", img[8*32 +: 8], 0);
    wr1(8'h21, 8'h77);
    check(img[8*33 +: 8] == 8'h77, "R8 fresh header", img[8*33 +: 8], 8'h77);
  endtask

  task automatic t_coinc;
    logic [7:0] d;
    logic r;
    sel(); xbyte(8'h02, rx); xbyte(8'h22, rx);
    for (int i = 7; i >= 1; i--) xbit(1'b1, r);
    mosi = 1'b1;
    wait_clk(8);
    sclk = 1'b1;
    cs_n = 1'b1;
    wait_clk(8);
    sclk = 1'b0;
    wait_clk(8);
    check(img[8*34 +: 8] == 8'h00, "R9 coincident image", img[8*34 +: 8], 0);
    rd1(8'h22, d);
    check(d == 8'h00, "R9 coincident read", d, 0);
  endtask

  task automatic t_badcmd;
    logic [7:0] d;
    sel(); xbyte(8'h04, rx); xbyte(8'h05, rx); xbyte(8'h00, d); desel();
    check(d == 8'h00, "R10 miso quiet", d, 0);
    check(img[8*5 +: 8] == 8'hA5, "R10 no write", img[8*5 +: 8], 8'hA5);
  endtask

  task automatic t_alt;
    logic [7:0] d;
    use_alt = 1'b1;
    sel(); xbyte(8'h40, rx); xbyte(8'h60, rx); xbyte(8'h3C, rx); desel();
    check(img2[8*48 +: 8] == 8'h3C, "R11 alt write", img2[8*48 +: 8], 8'h3C);
    sel(); xbyte(8'h60, rx); xbyte(8'h60, rx); xbyte(8'h00, d); desel();
    check(d == 8'h3C, "R11 alt read", d, 8'h3C);
    sel(); xbyte(8'h60, rx); xbyte(8'h00, rx); xbyte(8'h00, d); desel();
    check(d == 8'h95, "R11 alt family", d, 8'h95);
    check(img[8*48 +: 8] == 8'h00, "R11 std untouched", img[8*48 +: 8], 0);
    use_alt = 1'b0;
  endtask

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_write();
    t_read();
    t_burst();
    t_family();
    t_run();
    t_range();
    t_abort();
    t_coinc();
    t_badcmd();
    t_alt();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule